// File: doc/BRIEF.md
# Emulated Real-Time-Clock Interrupt Generator

This block recreates three real-time-clock interrupt sources on top of a single one-shot compare channel watching a free-running 32-bit counter. It produces a once-per-second update event, a time-of-day alarm, and periodic interrupts at power-of-two rates from 2 Hz to 8192 Hz. The counter value and the current hours, minutes and seconds come from outside. The block keeps the next compare target itself. On every tick it samples the time of day and decides which events fire.

Software supplies two precomputed counter deltas. The first is the interval of the 64 Hz base tick. The second is the interval of the requested periodic rate, used only when that rate is above 64 Hz. Slower periodic rates are made by dividing the base tick. When the counter has run past one or more targets, the block steps the target forward until it is ahead again. Each skipped tick counts as lost. Lost ticks are credited to the periodic divider and gathered in a saturating counter that clears on read.

Top module: `rtc_irq_emul`

## Requirements
- R1: When any enable rises from the all-clear state, the channel arms on the next clock edge with `cmp_target` = `cnt_now` + current interval and `armed` = 1.
- R2: A tick occurs when the armed target is not ahead of `cnt_now`. Here "A ahead of B" means bit 31 of (B − A) is 1, so the comparison is safe across 32-bit wrap. While the target is ahead, `cmp_target` stays unchanged and no interrupt is raised.
- R3: On a tick, the target advances by one interval per cycle until it is ahead of `cnt_now`. Every advance after the first is a lost tick. With k lost ticks, `irq_valid` appears k+2 clock edges after the counter reaches the target.
- R4: The update flag (word bit 4) is set on a tick when the sampled seconds differ from the seconds sampled on the previous tick. On the first tick after `upd_en` rises, the seconds are only recorded.
- R5: The alarm flag (word bit 5) is set on a tick when `alm_en` is 1 and hours, minutes and seconds all equal the alarm registers.
- R6: For `per_rate_log2` r in 1..6 (rate 2^r Hz), the periodic flag (word bit 6) is set once every 64>>r ticks. Lost ticks count toward that divider. An r of 0 is treated as 1.
- R7: For r in 7..13, the interval becomes `fast_delta` and every tick sets the periodic flag. Values above 13 are treated as 13.
- R8: The word carries bit 7 as the summary bit, bits 6:4 as the flags, and 0x01 in bits 15:8. `irq_valid` pulses for one cycle only when some flag is set, and `irq_word` is 0 otherwise.
- R9: `lost_cnt` accumulates lost ticks and saturates at 255. A one-cycle `lost_rd` clears it on the next edge.
- R10: With all three enables clear, the channel disarms on the next edge and raises no interrupt, whatever the counter does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_now | input | 32 | Free-running counter value |
| tod_hour | input | 5 | Current hours |
| tod_min | input | 6 | Current minutes |
| tod_sec | input | 6 | Current seconds |
| upd_en | input | 1 | Update interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| alm_hour | input | 5 | Alarm hours |
| alm_min | input | 6 | Alarm minutes |
| alm_sec | input | 6 | Alarm seconds |
| per_rate_log2 | input | 4 | log2 of requested periodic rate |
| base_delta | input | 32 | Counter interval of the 64 Hz tick |
| fast_delta | input | 32 | Counter interval of a rate above 64 Hz |
| lost_rd | input | 1 | Read strobe, clears the lost-tick count |
| irq_valid | output | 1 | One-cycle interrupt pulse |
| irq_word | output | 16 | Interrupt count and flag bits |
| lost_cnt | output | 8 | Saturating lost-tick count |
| armed | output | 1 | Compare channel armed |
| cmp_target | output | 32 | Current compare target |

## Verification
Arming shows on `armed` and `cmp_target` one edge after the enable changes. An interrupt for a tick with k lost ticks is due exactly k+2 edges after the counter is set at or past the target. The bench holds the counter for that many edges and then samples at the falling edge. A missing pulse there, or one that arrives early or late, is a miscompare. The lost-tick count and the advanced target are sampled in the same cycle as the interrupt, and the read clear is checked one edge after the strobe.

// File: rtl/rtc_emul_pkg.sv
package rtc_emul_pkg;
  localparam int CNT_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CATCH} sched_st_e;

  localparam logic [7:0] FLG_SUM = 8'h80;
  localparam logic [7:0] FLG_PER = 8'h40;
  localparam logic [7:0] FLG_ALM = 8'h20;
  localparam logic [7:0] FLG_UPD = 8'h10;

  // a ahead of b: (b - a) read as signed is negative
  function automatic logic cnt_ahead(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    logic [CNT_W-1:0] d;
    d = b - a;
    return d[CNT_W-1];
  endfunction

  function automatic logic [3:0] clamp_rate(input logic [3:0] r);
    if (r == 4'd0) return 4'd1;
    if (r > 4'd13) return 4'd13;
    return r;
  endfunction

  // base ticks per periodic event; 0 means every tick
  function automatic logic [6:0] pie_limit(input logic [3:0] r);
    if (r > 4'd6) return 7'd0;
    return 7'd64 >> r;
  endfunction
endpackage

// File: rtl/tick_sched.sv
module tick_sched
  import rtc_emul_pkg::*;
#(
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_en,
  input  logic [CNT_W-1:0]  cnt_now,
  input  logic [CNT_W-1:0]  delta,
  output logic              armed,
  output logic [CNT_W-1:0]  target,
  output logic              done,
  output logic [LOST_W-1:0] lost_tick
);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  sched_st_e         st_q;
  logic [CNT_W-1:0]  tgt_q;
  logic [LOST_W-1:0] lost_q;
  logic              reached;
  logic              adv;

  assign reached   = (st_q == ST_WAIT) && !cnt_ahead(tgt_q, cnt_now);
  assign done      = (st_q == ST_CATCH) && cnt_ahead(tgt_q, cnt_now);
  assign adv       = reached || ((st_q == ST_CATCH) && !done);
  assign armed     = (st_q != ST_IDLE);
  assign target    = tgt_q;
  assign lost_tick = lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= '0;
      lost_q <= '0;
    end else if (!any_en) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          tgt_q <= cnt_now + delta;
          st_q  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (reached) begin
            tgt_q  <= tgt_q + delta;
            lost_q <= '0;
            st_q   <= ST_CATCH;
          end
        end
        ST_CATCH: begin
          if (done) begin
            st_q <= ST_WAIT;
          end else begin
            tgt_q <= tgt_q + delta;
            if (lost_q != LOST_MAX) lost_q <= lost_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: each advance moves the target by exactly one interval
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && any_en) |=> (tgt_q == $past(tgt_q) + $past(delta)));
  // R10: all enables clear disarms the channel
  p_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> !armed);
  // R2: a tick never completes with the target still behind the counter
  p_ahead_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && any_en) |=> (st_q == ST_WAIT));
endmodule

// File: rtl/event_eval.sv
module event_eval
  import rtc_emul_pkg::*;
#(
  parameter int LOST_W = 8,
  parameter int PIE_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [LOST_W-1:0] lost_tick,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [3:0]        rate,
  input  logic [4:0]        tod_hour,
  input  logic [5:0]        tod_min,
  input  logic [5:0]        tod_sec,
  input  logic [4:0]        alm_hour,
  input  logic [5:0]        alm_min,
  input  logic [5:0]        alm_sec,
  output logic              irq_valid,
  output logic [15:0]       irq_word
);
  logic [5:0]       prev_sec_q;
  logic             prev_ok_q;
  logic [PIE_W-1:0] pie_q;
  logic [PIE_W-1:0] pie_sum;
  logic [6:0]       limit;
  logic             upd_hit, alm_hit, per_hit;
  logic [7:0]       flags;

  assign limit   = pie_limit(rate);
  assign pie_sum = pie_q + PIE_W'(lost_tick) + PIE_W'(1);
  assign upd_hit = upd_en && prev_ok_q && (tod_sec != prev_sec_q);
  assign alm_hit = alm_en && (tod_hour == alm_hour) && (tod_min == alm_min) &&
                   (tod_sec == alm_sec);
  assign per_hit = per_en && ((limit == 7'd0) || (pie_sum >= PIE_W'(limit)));
  assign flags   = (upd_hit ? FLG_UPD : 8'h00) | (alm_hit ? FLG_ALM : 8'h00) |
                   (per_hit ? FLG_PER : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sec_q <= '0;
      prev_ok_q  <= 1'b0;
      pie_q      <= '0;
      irq_valid  <= 1'b0;
      irq_word   <= '0;
    end else begin
      if (!upd_en) prev_ok_q <= 1'b0;
      else if (done) begin
        prev_sec_q <= tod_sec;
        prev_ok_q  <= 1'b1;
      end
      if (!per_en) pie_q <= '0;
      else if (done) pie_q <= per_hit ? '0 : pie_sum;
      if (done && (flags != 8'h00)) begin
        irq_valid <= 1'b1;
        irq_word  <= {8'h01, FLG_SUM | flags};
      end else begin
        irq_valid <= 1'b0;
        irq_word  <= '0;
      end
    end
  end

  // R4: first tick after enabling update only records the seconds
  p_first_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && upd_en && !prev_ok_q) |=> !irq_word[4]);
  // R8: word layout when an interrupt is raised
  p_word_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_word[15:8] == 8'h01) && irq_word[7] && (irq_word[6:4] != 3'b000));
  // R8: quiet word when nothing fires
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_word == 16'h0000));
  // R8: pulse lasts one cycle per tick
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(irq_valid) || $past(done));
endmodule

// File: rtl/lost_acc.sv
module lost_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic [W-1:0] lost_tick,
  input  logic         rd,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT = '1;

  logic [W:0]   sum;
  logic [W-1:0] base;
  logic [W-1:0] add;

  assign base = rd ? '0 : cnt;
  assign add  = done ? lost_tick : '0;
  assign sum  = {1'b0, base} + {1'b0, add};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sum[W] ? SAT : sum[W-1:0];
  end

  // R9: saturated count holds until read
  p_lost_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) == SAT && !$past(rd)) |-> (cnt == SAT));
  // R9: count never decreases without a read
  p_lost_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> (cnt >= $past(cnt)));
endmodule

// File: rtl/rtc_irq_emul.sv
module rtc_irq_emul
  import rtc_emul_pkg::*;
#(
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cnt_now,
  input  logic [4:0]        tod_hour,
  input  logic [5:0]        tod_min,
  input  logic [5:0]        tod_sec,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [4:0]        alm_hour,
  input  logic [5:0]        alm_min,
  input  logic [5:0]        alm_sec,
  input  logic [3:0]        per_rate_log2,
  input  logic [31:0]       base_delta,
  input  logic [31:0]       fast_delta,
  input  logic              lost_rd,
  output logic              irq_valid,
  output logic [15:0]       irq_word,
  output logic [LOST_W-1:0] lost_cnt,
  output logic              armed,
  output logic [31:0]       cmp_target
);
  localparam int PIE_W = LOST_W + 2;

  logic [3:0]        rate;
  logic              fast;
  logic [CNT_W-1:0]  delta;
  logic              any_en;
  logic              tick_done;
  logic [LOST_W-1:0] lost_tick;

  assign rate   = clamp_rate(per_rate_log2);
  assign fast   = per_en && (rate > 4'd6);
  assign delta  = fast ? fast_delta : base_delta;
  assign any_en = upd_en || alm_en || per_en;

  tick_sched #(.LOST_W(LOST_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .any_en(any_en), .cnt_now(cnt_now), .delta(delta),
    .armed(armed), .target(cmp_target), .done(tick_done), .lost_tick(lost_tick)
  );

  event_eval #(.LOST_W(LOST_W), .PIE_W(PIE_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .done(tick_done), .lost_tick(lost_tick),
    .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en), .rate(rate),
    .tod_hour(tod_hour), .tod_min(tod_min), .tod_sec(tod_sec),
    .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
    .irq_valid(irq_valid), .irq_word(irq_word)
  );

  lost_acc #(.W(LOST_W)) u_lost (
    .clk(clk), .rst_n(rst_n), .done(tick_done), .lost_tick(lost_tick),
    .rd(lost_rd), .cnt(lost_cnt)
  );

  // R10: no interrupt one edge after all enables are clear
  p_no_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !$past(any_en)) |-> !irq_valid);
  // R1: arming loads counter plus interval
  p_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && any_en) |=> (armed && cmp_target == $past(cnt_now) + $past(delta)));
endmodule

// File: tb/rtc_irq_emul_test.sv
module rtc_irq_emul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt_now = '0;
  logic [4:0]  tod_hour = '0, alm_hour = '0;
  logic [5:0]  tod_min = '0, tod_sec = '0, alm_min = '0, alm_sec = '0;
  logic        upd_en = 0, alm_en = 0, per_en = 0, lost_rd = 0;
  logic [3:0]  per_rate_log2 = 4'd1;
  logic [31:0] base_delta = 32'd100, fast_delta = 32'd7;
  logic        irq_valid, armed;
  logic [15:0] irq_word;
  logic [7:0]  lost_cnt;
  logic [31:0] cmp_target;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] tgt;

  always #10 clk = ~clk;

  rtc_irq_emul uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive counter, wait k+2 edges, sample
  task automatic tick(input logic [31:0] c, input int k);
    cnt_now = c;
    step(k + 2);
  endtask

  task automatic all_off();
    upd_en = 0; alm_en = 0; per_en = 0;
    step(1);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R8 reset irq_valid", irq_valid, 0);
    check("R10 reset armed", armed, 0);
    check("R9 reset lost_cnt", lost_cnt, 0);

    // R1 arm and R4 update
    cnt_now = 32'd1000; base_delta = 32'd100; tod_sec = 6'd5;
    upd_en = 1; step(1);
    check("R1 armed", armed, 1);
    check("R1 target", cmp_target, 32'd1100);
    tick(32'd1100, 0);
    check("R4 first tick records only", irq_valid, 0);
    tod_sec = 6'd6;
    tick(32'd1200, 0);
    check("R4 seconds changed valid", irq_valid, 1);
    check("R8 update word", irq_word, 32'h0190);
    step(1);
    check("R8 one-cycle pulse", irq_valid, 0);
    tick(32'd1300, 0);
    check("R4 same seconds no irq", irq_valid, 0);

    // R3 catch-up with two lost ticks, R9 count and clear
    tod_sec = 6'd7;
    tick(32'd1650, 2);
    check("R3 irq after k+2 edges", irq_valid, 1);
    check("R3 word", irq_word, 32'h0190);
    check("R3 target past counter", cmp_target, 32'd1700);
    check("R9 lost count", lost_cnt, 8'd2);
    lost_rd = 1; step(1); lost_rd = 0;
    check("R9 clear on read", lost_cnt, 0);

    // R5 alarm with update
    alm_hour = 5'd10; alm_min = 6'd20; alm_sec = 6'd30; alm_en = 1;
    tod_hour = 5'd10; tod_min = 6'd20; tod_sec = 6'd30;
    tick(32'd1700, 0);
    check("R5 alarm+update word", irq_word, 32'h01B0);
    tod_min = 6'd21;
    tick(32'd1800, 0);
    check("R5 alarm mismatch no irq", irq_valid, 0);

    // R6 periodic divider sweep over rates 2..64 Hz
    for (int r = 1; r <= 6; r++) begin
      int hits;
      all_off();
      hits = 0;
      base_delta = 32'd10; cnt_now = 32'd0; per_rate_log2 = 4'(r);
      per_en = 1; step(1);
      tgt = 32'd10;
      for (int i = 0; i < 64; i++) begin
        tick(tgt, 0);
        tgt = tgt + 32'd10;
        if (irq_valid) begin
          hits++;
          check("R6 periodic word", irq_word, 32'h01C0);
        end
      end
      check("R6 periodic count per 64 ticks", hits, 32'd1 << r);
    end

    // R6 lost ticks credited to divider (rate 2 Hz, limit 32)
    all_off();
    per_rate_log2 = 4'd1; base_delta = 32'd10; cnt_now = 32'd0;
    per_en = 1; step(1);
    tick(32'd10 + 32'd400, 40);
    check("R6 lost ticks reach divider", irq_word, 32'h01C0);
    tick(cmp_target, 0);
    check("R6 divider restarted", irq_valid, 0);
    lost_rd = 1; step(1); lost_rd = 0;

    // R7 fast rates
    for (int r = 7; r <= 15; r += 4) begin
      all_off();
      per_rate_log2 = 4'(r); fast_delta = 32'd7; base_delta = 32'd100; cnt_now = 32'd500;
      per_en = 1; step(1);
      check("R7 fast interval", cmp_target, 32'd507);
      tick(32'd507, 0);
      check("R7 every tick periodic", irq_word, 32'h01C0);
      check("R7 target step", cmp_target, 32'd514);
      tick(32'd514, 0);
      check("R7 next tick periodic", irq_valid, 1);
    end

    // R2 wrap-safe compare
    all_off();
    base_delta = 32'h20; cnt_now = 32'hFFFF_FFF0;
    tod_hour = 5'd10; tod_min = 6'd20; tod_sec = 6'd30;
    alm_en = 1; step(1);
    check("R2 wrapped target", cmp_target, 32'h10);
    cnt_now = 32'hFFFF_FFF8; step(3);
    check("R2 no tick before wrap", irq_valid, 0);
    check("R2 target held", cmp_target, 32'h10);
    tick(32'h10, 0);
    check("R2 tick after wrap", irq_word, 32'h01A0);
    check("R2 target advanced", cmp_target, 32'h30);

    // R9 saturation
    base_delta = 32'd1;
    tick(32'h30 + 32'd300, 300);
    check("R9 saturates", lost_cnt, 8'd255);
    step(2);
    check("R9 holds saturated", lost_cnt, 8'd255);
    lost_rd = 1; step(1); lost_rd = 0;
    check("R9 clears after saturation", lost_cnt, 0);

    // R10 disarm
    all_off();
    check("R10 disarmed", armed, 0);
    cnt_now = 32'h8000_0000; step(1);
    check("R10 no irq a", irq_valid, 0);
    step(3);
    check("R10 no irq b", irq_valid, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule